// File: doc/BRIEF.md
# Overcurrent Alert and Status Logic

This block decides when a supply-monitoring device raises its alert line. It merges two independent views of load current: a live flag from an analog comparator that trips when the sensed current exceeds an externally set level, and the stream of 12-bit current-channel conversion results. The comparator path is filtered by a delay counter. That counter stands in for an external timing capacitor, so a short inrush does not latch a fault. The digital path compares the upper eight bits of each result with a programmable threshold. It can fire on one over-threshold result or only on a run of four in a row.

Each fault source has a sticky status bit. The alert output is the OR of those latched bits, each gated by its own enable. Software controls the block with single-byte writes to three registers: an enable register, a threshold register and a control register. The enable register also carries a one-shot clear command. The control register carries a software-off bit, which can force the alert line high, for example to turn off a series pass transistor. An active-low clear pin releases a latched comparator fault.

Top module: `ocp_alert_monitor`

## Requirements
- R1: After reset the alert output is 0 and status bits 0, 1, 3, 4 and 5 are 0. The threshold is 0xFF and the enable register holds only bit 2 set. A write with select 0 changes nothing.
- R2: Each result with `cur_valid` high is over threshold when its bits [11:4] are strictly greater than the threshold register (select 2). Status bit 0 is 1 while the most recent result was over threshold.
- R3: With enable bit 0 set, the cycle after an over-threshold result is registered, status bit 1 latches.
- R4: With enable bit 1 set, status bit 1 latches only once four consecutive results have been over threshold. A result at or below the threshold restarts the run. The run count saturates at four.
- R5: The timer counts clock cycles while `oc_cmp` is high and returns to zero when it drops. Once it reaches `DELAY`, status bit 3 latches on the next edge if enable bit 2 is set. A shorter pulse latches nothing.
- R6: Status bit 2 equals the present value of `oc_cmp`.
- R7: Writing bit 0 of the control register (select 3) sets status bit 4. Status bit 5 latches from it only while enable bit 3 is set.
- R8: Writing the enable register (select 1) with bit 4 set clears status bits 1, 3 and 5 on that edge. Bit 4 is not kept. A bit whose cause persists sets again on the following edge.
- R9: While `clr_n` is low, status bit 3 is held clear. Status bits 1 and 5 are not affected.
- R10: The alert output is high exactly when one of these holds: status bit 1 is set and enable bit 0 or 1 is set; status bit 3 is set with enable bit 2; or status bit 5 is set with enable bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low clear of the latched comparator fault |
| oc_cmp | input | 1 | Comparator overcurrent flag |
| cur_valid | input | 1 | Strobe marking a new current result |
| cur_data | input | RES_W | Current-channel conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 1 enable, 2 threshold, 3 control |
| reg_wdata | input | TH_W | Register write data |
| alert | output | 1 | Active-high alert level |
| status | output | 6 | Status word |

## Verification
Results are sent just at and just above the threshold, so that the strictly-greater test and the use of the upper eight bits both show. Runs of three over-threshold results broken by one low result tell single-trip mode apart from four-in-a-row mode. Comparator pulses one cycle short of the delay, followed by a long hold, separate filtered glitches from real faults. Clearing while the comparator stays high shows the immediate re-latch. Software-off is issued with its enable both cleared and set, which shows that the status bit is independent of the alert gating.

// File: rtl/ocp_alert_monitor.sv
module ocp_alert_monitor #(
  parameter int RES_W   = 12,
  parameter int TH_W    = 8,
  parameter int RUN_LEN = 4,
  parameter int DELAY   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             oc_cmp,
  input  logic             cur_valid,
  input  logic [RES_W-1:0] cur_data,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [TH_W-1:0]  reg_wdata,
  output logic             alert,
  output logic [5:0]       status
);
  localparam int CW = $clog2(DELAY + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [TH_W-1:0] th;
  logic [3:0]      en;
  logic            sw_off, last_over, adc_al, oc_al, off_al;
  logic [RW-1:0]   run;
  logic [CW-1:0]   tcnt;

  wire en_wr    = reg_wr && (reg_sel == 2'd1);
  wire th_wr    = reg_wr && (reg_sel == 2'd2);
  wire ctl_wr   = reg_wr && (reg_sel == 2'd3);
  wire clr_cmd  = en_wr && reg_wdata[4];
  wire over     = cur_data[RES_W-1 -: TH_W] > th;
  wire run_full = run == RW'(RUN_LEN);
  wire t_done   = tcnt == CW'(DELAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th     <= '1;
      en     <= 4'b0100;
      sw_off <= 1'b0;
    end else begin
      if (th_wr)  th     <= reg_wdata;
      if (en_wr)  en     <= reg_wdata[3:0];
      if (ctl_wr) sw_off <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_over <= 1'b0;
      run       <= '0;
    end else if (cur_valid) begin
      last_over <= over;
      if (!over)         run <= '0;
      else if (!run_full) run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt <= '0;
    else if (!oc_cmp) tcnt <= '0;
    else if (!t_done) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_al <= 1'b0;
      oc_al  <= 1'b0;
      off_al <= 1'b0;
    end else begin
      if (clr_cmd) adc_al <= 1'b0;
      else if ((en[0] && last_over) || (en[1] && run_full)) adc_al <= 1'b1;
      if (clr_cmd || !clr_n) oc_al <= 1'b0;
      else if (en[2] && t_done) oc_al <= 1'b1;
      if (clr_cmd) off_al <= 1'b0;
      else if (en[3] && sw_off) off_al <= 1'b1;
    end
  end

  assign status = {off_al, sw_off, oc_al, oc_cmp, adc_al, last_over};
  assign alert  = (adc_al && (en[0] || en[1])) || (oc_al && en[2]) || (off_al && en[3]);

  // R10
  alert_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (status[1] || status[3] || status[5]));
  // R9
  clear_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !status[3]);
  // R8
  clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (!status[1] && !status[3] && !status[5]));
  // R5
  timer_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(t_done));
  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(RUN_LEN));
  // R7
  sw_off_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_off && en[3] && !clr_cmd) |=> status[5]);
endmodule

// File: tb/tb_ocp_alert_monitor.sv
module tb_ocp_alert_monitor;
  localparam int DELAY = 16;
  logic clk = 0, rst_n = 0, clr_n = 1, oc_cmp = 0, cur_valid = 0, reg_wr = 0;
  logic [11:0] cur_data = '0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        alert;
  logic [5:0]  status;
  int tests = 0, fails = 0;
  bit run_cmp = 0;

  always #4 clk = ~clk;

  ocp_alert_monitor #(.DELAY(DELAY)) dut (.*);

  int m_th, m_en, m_sw, m_last, m_run, m_t, m_s1, m_s3, m_s5;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_th = 255; m_en = 4; m_sw = 0; m_last = 0; m_run = 0; m_t = 0;
      m_s1 = 0; m_s3 = 0; m_s5 = 0;
    end else begin
      automatic bit clr = reg_wr && reg_sel == 1 && reg_wdata[4];
      automatic bit s1 = m_s1 || ((m_en & 1) && m_last) || ((m_en & 2) && m_run == 4);
      automatic bit s3 = m_s3 || ((m_en & 4) && m_t == DELAY);
      automatic bit s5 = m_s5 || ((m_en & 8) && m_sw);
      m_s1 = clr ? 0 : s1;
      m_s3 = (clr || !clr_n) ? 0 : s3;
      m_s5 = clr ? 0 : s5;
      m_t = oc_cmp ? ((m_t < DELAY) ? m_t + 1 : DELAY) : 0;
      if (cur_valid) begin
        automatic bit ov = (cur_data >> 4) > m_th;
        m_last = ov;
        m_run = ov ? ((m_run < 4) ? m_run + 1 : 4) : 0;
      end
      if (reg_wr && reg_sel == 1) m_en = reg_wdata & 15;
      if (reg_wr && reg_sel == 2) m_th = reg_wdata;
      if (reg_wr && reg_sel == 3) m_sw = reg_wdata[0];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    automatic int ea = (m_s1 && (m_en & 3) != 0) || (m_s3 && (m_en & 4) != 0) || (m_s5 && (m_en & 8) != 0);
    chk("R2 status0", status[0], m_last);
    chk("R3 R4 status1", status[1], m_s1);
    chk("R6 status2", status[2], oc_cmp);
    chk("R5 R9 status3", status[3], m_s3);
    chk("R7 status4", status[4], m_sw);
    chk("R7 status5", status[5], m_s5);
    chk("R10 alert", alert, ea);
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input int sel, input int data);
    reg_wr = 1; reg_sel = 2'(sel); reg_wdata = 8'(data);
    tick(1);
    reg_wr = 0;
  endtask

  task automatic sample(input int data);
    cur_valid = 1; cur_data = 12'(data);
    tick(1);
    cur_valid = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    run_cmp = 1;
    chk("R1 alert", alert, 0);
    chk("R1 status", int'(status), 0);
    wr(0, 8'h1F);
    tick(1);
    chk("R1 sel0 ignored", int'(status), 0);
    // R2 default threshold 0xFF never exceeded; R3 single trip
    wr(1, 8'h01);
    sample(12'hFFF); tick(2);
    chk("R2 at 0xFF", status[0], 0);
    wr(2, 8'h80);
    sample(12'h80F); tick(1);
    chk("R2 equal not over", status[0], 0);
    sample(12'h810); tick(1);
    chk("R3 single latch", status[1], 1);
    sample(12'h100); tick(2);
    chk("R3 sticky", status[1], 1);
    wr(1, 8'h10); tick(1);
    // R4 four consecutive
    wr(1, 8'h02);
    repeat (3) sample(12'h900);
    sample(12'h700);
    repeat (3) sample(12'h900);
    tick(2);
    chk("R4 run broken", status[1], 0);
    sample(12'h900); tick(2);
    chk("R4 four latch", status[1], 1);
    repeat (3) sample(12'hA00);
    wr(1, 8'h14); tick(3);
    // R5 timer
    oc_cmp = 1; tick(DELAY - 1); oc_cmp = 0; tick(3);
    chk("R5 short pulse", status[3], 0);
    oc_cmp = 1; tick(DELAY + 3);
    chk("R5 latched", status[3], 1);
    chk("R10 alert oc", alert, 1);
    // R8 clear while cause persists
    wr(1, 8'h14);
    chk("R8 cleared", status[3], 0);
    tick(1);
    chk("R8 relatch", status[3], 1);
    // R9 clear pin
    clr_n = 0; tick(1);
    chk("R9 pin clear", status[3], 0);
    oc_cmp = 0; tick(2); clr_n = 1; tick(2);
    chk("R9 stays clear", status[3], 0);
    // R7 software off
    wr(3, 1); tick(2);
    chk("R7 status4", status[4], 1);
    chk("R7 gated", status[5], 0);
    wr(1, 8'h0C); tick(2);
    chk("R7 latched", status[5], 1);
    clr_n = 0; tick(1);
    chk("R9 leaves bit5", status[5], 1);
    clr_n = 1;
    wr(3, 0);
    wr(1, 8'h18); tick(2);
    chk("R8 bit5 cleared", status[5], 0);
    wr(1, 8'h00); tick(3);
    run_cmp = 0;
    finish_run();
  end
endmodule